// File: doc/BRIEF.md
# Sequenced-Arm Watchdog Timer

This peripheral guards a system against software that has stopped running. A bus-side register file, clocked by the system clock, feeds an up-counter that runs from a separate slow timer clock. The counter can be slowed by a power-of-two prescaler. When the counter rolls over past all ones while the watchdog is armed, the block raises a one-cycle reset request toward the reset controller and restarts counting from the load value. Software keeps the system alive by writing a new trigger value before the rollover. Each such write copies the load value into the counter.

Every write to the control, load, trigger and start/stop registers is posted. The bus side keeps the value, raises a per-register pending flag, and passes a toggle across to the timer domain. The flag clears once the value has been applied there. A write that arrives while its register is still pending is dropped. Arming and disarming each need a two-word sequence written to the start/stop register, so that a single stray store cannot change the state. While the watchdog is armed, the prescaler and load settings are locked.

Top module: `wdog_seq_timer`

## Requirements
- R1: Word addresses are: revision 0, control 1, count 2, load 3, trigger 4, pending 5, start/stop 6. Reads return data one clock after `rd_en` with `rvalid` high. Revision bits 7:0 hold the fixed code 0x5A.
- R2: After reset the block is armed (start/stop read bit 0 = 1), load reads the default 0xFFFFF000, control reads 0 and pending reads 0.
- R3: Writing 0xBBBB and then 0x4444 as consecutive start/stop words arms the watchdog.
- R4: Writing 0xAAAA and then 0x5555 as consecutive start/stop words disarms the watchdog.
- R5: If the second word of a sequence is anything other than its partner, the armed state is left unchanged and detection starts again. Examples: 0xBBBB,0x1234,0x4444 leaves the block disarmed; 0xAAAA,0xBBBB,0x5555 leaves it armed.
- R6: Pending bit 0 covers control, bit 2 load, bit 3 trigger and bit 4 start/stop. A bit is set from the clock after its write until the value has been applied in the timer domain. Another write to that register during this time is dropped.
- R7: A trigger write reloads the counter (and the prescaler phase) from load only when its value differs from the previous trigger value. Rewriting the same value leaves the count as it was.
- R8: While the watchdog is armed, control and load writes have no effect.
- R9: The counter advances by one per prescaled timer tick only while armed, and holds while disarmed. The count register returns its value at any time.
- R10: Control bit 5 enables the prescaler and bits 4:2 give the ratio p. When enabled, one tick occurs every 2^p timer clocks; otherwise one occurs every timer clock.
- R11: When the counter is all ones and a tick occurs while armed, `rst_req` is high for one timer clock (when load is not all ones) and the counter returns to the load value. No pulse is produced while disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| tclk | input | 1 | Slow timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one clock after rd_en |
| rst_req | output | 1 | Reset request pulse, timer clock domain |

## Verification
A wrong sequence state does not show at once. It shows only when a later start/stop word arms or disarms when it should not, and the armed bit then reads back a few clocks after that pending flag clears. A stale trigger value or a broken reload shows on the next count read as a count that was not reset to the load value. A prescaler or counter fault changes how far the count advances between arming and disarming, and a fault in the overflow path moves or widens the `rst_req` pulses within tens of timer clocks.

// File: rtl/wdog_seq_timer.sv
module wdog_seq_timer #(
  parameter int              DW           = 32,
  parameter int              AW           = 3,
  parameter int              PRW          = 3,
  parameter logic [DW-1:0]   DEFAULT_LOAD = 32'hFFFF_F000,
  parameter logic [7:0]      REV_CODE     = 8'h5A
) (
  input  logic          clk,
  input  logic          tclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          rst_req
);
  localparam int PCW = (1 << PRW) - 1;
  localparam int NCH = 4;
  localparam int CH_CTRL = 0, CH_LOAD = 1, CH_TRIG = 2, CH_ARM = 3;
  localparam logic [AW-1:0] A_REV = 0, A_CTRL = 1, A_CNT = 2, A_LOAD = 3,
                            A_TRIG = 4, A_PEND = 5, A_ARM = 6;
  localparam logic [DW-1:0] W_ARM1 = DW'(16'hBBBB), W_ARM2 = DW'(16'h4444),
                            W_DIS1 = DW'(16'hAAAA), W_DIS2 = DW'(16'h5555);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM1, SQ_DIS1} seq_t;

  logic [NCH-1:0] req_tg, ack_s1, ack_s2, pend, wsel;
  logic [PRW:0]   ctrl_h;
  logic [DW-1:0]  load_h, trig_h, arm_h;
  logic [DW-1:0]  gray_s1, gray_s2, cnt_rd;
  logic           arm_s1, arm_s2;

  logic [1:0]     trst;
  logic           t_rst_n;
  logic [NCH-1:0] req_s1, req_s2, req_s3, apply;
  logic           pre_en;
  logic [PRW-1:0] pre_ratio;
  logic [PCW-1:0] pre_cnt, pre_lim;
  logic [DW-1:0]  load_q, trig_last, count_q, gray_q;
  logic           armed_q, rst_req_q, trig_new, tick, ovf;
  seq_t           seq_q;

  assign pend = req_tg ^ ack_s2;
  assign wsel[CH_CTRL] = wr_en && addr == A_CTRL && !pend[CH_CTRL];
  assign wsel[CH_LOAD] = wr_en && addr == A_LOAD && !pend[CH_LOAD];
  assign wsel[CH_TRIG] = wr_en && addr == A_TRIG && !pend[CH_TRIG];
  assign wsel[CH_ARM]  = wr_en && addr == A_ARM  && !pend[CH_ARM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tg  <= '0;
      ack_s1  <= '0;
      ack_s2  <= '0;
      ctrl_h  <= '0;
      load_h  <= DEFAULT_LOAD;
      trig_h  <= '0;
      arm_h   <= '0;
      gray_s1 <= '0;
      gray_s2 <= '0;
      arm_s1  <= 1'b1;
      arm_s2  <= 1'b1;
    end else begin
      req_tg  <= req_tg ^ wsel;
      ack_s1  <= req_s3;
      ack_s2  <= ack_s1;
      gray_s1 <= gray_q;
      gray_s2 <= gray_s1;
      arm_s1  <= armed_q;
      arm_s2  <= arm_s1;
      if (wsel[CH_CTRL]) ctrl_h <= wdata[PRW+2:2];
      if (wsel[CH_LOAD]) load_h <= wdata;
      if (wsel[CH_TRIG]) trig_h <= wdata;
      if (wsel[CH_ARM])  arm_h  <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < DW; i++) cnt_rd[i] = ^(gray_s2 >> i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (addr)
          A_REV:   rdata <= DW'(REV_CODE);
          A_CTRL:  rdata <= DW'({pre_en, pre_ratio, 2'b00});
          A_CNT:   rdata <= cnt_rd;
          A_LOAD:  rdata <= load_q;
          A_TRIG:  rdata <= trig_h;
          A_PEND:  rdata <= DW'({pend[CH_ARM], pend[CH_TRIG], pend[CH_LOAD], 1'b0, pend[CH_CTRL]});
          A_ARM:   rdata <= DW'(arm_s2);
          default: rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) trst <= '0;
    else        trst <= {trst[0], 1'b1};
  end
  assign t_rst_n = trst[1];

  assign apply    = req_s2 ^ req_s3;
  assign trig_new = apply[CH_TRIG] && (trig_h != trig_last);
  assign pre_lim  = (PCW'(1) << pre_ratio) - PCW'(1);
  assign tick     = armed_q && (!pre_en || pre_cnt == pre_lim);
  assign ovf      = tick && (&count_q);
  assign rst_req  = rst_req_q;

  always_ff @(posedge tclk or negedge t_rst_n) begin
    if (!t_rst_n) begin
      req_s1    <= '0;
      req_s2    <= '0;
      req_s3    <= '0;
      pre_en    <= 1'b0;
      pre_ratio <= '0;
      pre_cnt   <= '0;
      load_q    <= DEFAULT_LOAD;
      trig_last <= '0;
      count_q   <= DEFAULT_LOAD;
      gray_q    <= '0;
      armed_q   <= 1'b1;
      seq_q     <= SQ_IDLE;
      rst_req_q <= 1'b0;
    end else begin
      req_s1    <= req_tg;
      req_s2    <= req_s1;
      req_s3    <= req_s2;
      rst_req_q <= 1'b0;
      gray_q    <= count_q ^ (count_q >> 1);
      if (apply[CH_CTRL] && !armed_q) {pre_en, pre_ratio} <= ctrl_h;
      if (apply[CH_LOAD] && !armed_q) load_q <= load_h;
      if (apply[CH_TRIG]) trig_last <= trig_h;
      if (apply[CH_ARM]) begin
        if (seq_q == SQ_ARM1 && arm_h == W_ARM2) begin
          armed_q <= 1'b1;
          seq_q   <= SQ_IDLE;
        end else if (seq_q == SQ_DIS1 && arm_h == W_DIS2) begin
          armed_q <= 1'b0;
          seq_q   <= SQ_IDLE;
        end else if (arm_h == W_ARM1) seq_q <= SQ_ARM1;
        else if (arm_h == W_DIS1)     seq_q <= SQ_DIS1;
        else                          seq_q <= SQ_IDLE;
      end
      if (trig_new) begin
        count_q <= load_q;
        pre_cnt <= '0;
      end else if (armed_q) begin
        pre_cnt <= tick ? '0 : pre_cnt + PCW'(1);
        if (ovf) begin
          count_q   <= load_q;
          rst_req_q <= 1'b1;
        end else if (tick) begin
          count_q <= count_q + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdog_seq_timer_chk.sv
module wdog_seq_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          tclk,
  input logic          rst_n,
  input logic          t_rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [3:0]    pend,
  input logic          armed_q,
  input logic          apply_arm,
  input logic [DW-1:0] arm_h,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] count_q,
  input logic          trig_new,
  input logic          rst_req
);
  AST_RST_ONE_CYCLE: assert property (@(posedge tclk) disable iff (!t_rst_n)
    (rst_req && load_q != '1) |=> !rst_req); // R11
  AST_RST_ONLY_ARMED: assert property (@(posedge tclk) disable iff (!t_rst_n)
    rst_req |-> $past(armed_q)); // R11
  AST_WRAP_TO_LOAD: assert property (@(posedge tclk) disable iff (!t_rst_n)
    rst_req |-> count_q == load_q); // R11
  AST_LOAD_LOCKED: assert property (@(posedge tclk) disable iff (!t_rst_n)
    $past(armed_q) |-> $stable(load_q)); // R8
  AST_ARM_ON_PARTNER: assert property (@(posedge tclk) disable iff (!t_rst_n)
    $rose(armed_q) |-> $past(apply_arm && arm_h == DW'(16'h4444))); // R3
  AST_DISARM_ON_PARTNER: assert property (@(posedge tclk) disable iff (!t_rst_n)
    $fell(armed_q) |-> $past(apply_arm && arm_h == DW'(16'h5555))); // R4
  AST_COUNT_HOLDS: assert property (@(posedge tclk) disable iff (!t_rst_n)
    $past(!armed_q && !trig_new) |-> $stable(count_q)); // R9
  AST_PEND_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> $past(wr_en && addr == AW'(3))); // R6
endmodule

bind wdog_seq_timer wdog_seq_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .tclk(tclk), .rst_n(rst_n), .t_rst_n(t_rst_n),
  .wr_en(wr_en), .addr(addr), .pend(pend), .armed_q(armed_q),
  .apply_arm(apply[3]), .arm_h(arm_h), .load_q(load_q),
  .count_q(count_q), .trig_new(trig_new), .rst_req(rst_req)
);

// File: tb/wdog_seq_timer_test.sv
`timescale 1ns/1ps
module wdog_seq_timer_test;
  logic        clk = 0, tclk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        rvalid, rst_req;

  wdog_seq_timer uut (.clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                      .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .rst_req(rst_req));

  always #2.5 clk = ~clk;
  initial begin #3; forever #20 tclk = ~tclk; end

  typedef struct { logic [31:0] mask, lo, hi; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0, pulses = 0, wide = 0;
  logic prev_req = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge tclk) begin
    if (rst_req) pulses++;
    if (rst_req && prev_req) wide++;
    prev_req = rst_req;
  end

  always @(negedge clk) begin
    if (rvalid && q.size() > 0) begin
      exp_t e;
      logic [31:0] v;
      e = q.pop_front();
      v = rdata & e.mask;
      checks++;
      if (v < e.lo || v > e.hi) begin
        fails++;
        $display("FAIL %s actual=%h expected=[%h..%h]", e.tag, v, e.lo, e.hi);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr_raw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_raw(a, d);
    repeat (64) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] m, input logic [31:0] lo,
                    input logic [31:0] hi, input string tag);
    exp_t e;
    e.mask = m; e.lo = lo; e.hi = hi; e.tag = tag;
    q.push_back(e);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    @(negedge clk);
  endtask

  task automatic rdx(input logic [2:0] a, input logic [31:0] v, input string tag);
    rd(a, 32'hFFFF_FFFF, v, v, tag);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0, dt, p0;
    logic [31:0] lo, hi;
    #52; rst_n = 1;
    repeat (20) @(negedge clk);
    rd(3'd0, 32'hFF, 32'h5A, 32'h5A, "R1 revision code");
    rdx(3'd6, 1, "R2 armed after reset");
    rdx(3'd3, 32'hFFFF_F000, "R2 default load");
    rdx(3'd1, 0, "R2 control reset");
    rdx(3'd5, 0, "R2 pending clear");

    wr(3'd6, 32'hAAAA); wr(3'd6, 32'h5555);
    rdx(3'd6, 0, "R4 disarm sequence");
    wr(3'd6, 32'hBBBB); wr(3'd6, 32'h1234); wr(3'd6, 32'h4444);
    rdx(3'd6, 0, "R5 broken arm sequence");

    wr_raw(3'd3, 32'h100);
    rd(3'd5, 32'h1D, 32'h04, 32'h04, "R6 load pending bit 2");
    wr_raw(3'd3, 32'h200);
    repeat (64) @(negedge clk);
    rdx(3'd3, 32'h100, "R6 write during pending dropped");
    rdx(3'd5, 0, "R6 pending cleared");
    wr_raw(3'd4, 32'h1111);
    rd(3'd5, 32'h1D, 32'h08, 32'h08, "R6 trigger pending bit 3");
    repeat (64) @(negedge clk);
    rdx(3'd2, 32'h100, "R7 trigger reloads count");

    wr(3'd6, 32'hBBBB); wr_raw(3'd6, 32'h4444); t0 = cyc;
    repeat (64) @(negedge clk);
    rdx(3'd6, 1, "R3 arm sequence");
    wr(3'd3, 32'h999);
    rdx(3'd3, 32'h100, "R8 load locked while armed");
    wr(3'd1, 32'h3C);
    rdx(3'd1, 0, "R8 control locked while armed");
    wr(3'd6, 32'hAAAA); wr(3'd6, 32'hBBBB); wr(3'd6, 32'h5555);
    rdx(3'd6, 1, "R5 broken disarm sequence");
    repeat (200) @(negedge clk);
    wr(3'd6, 32'hAAAA); wr_raw(3'd6, 32'h5555); dt = cyc - t0;
    repeat (64) @(negedge clk);
    lo = 32'h100 + dt / 8 - 4; hi = 32'h100 + dt / 8 + 4;
    rd(3'd2, 32'hFFFF_FFFF, lo, hi, "R9 count advance unscaled");
    repeat (100) @(negedge clk);
    rd(3'd2, 32'hFFFF_FFFF, lo, hi, "R9 count holds while disarmed");
    wr(3'd4, 32'h1111);
    rd(3'd2, 32'hFFFF_FFFF, lo, hi, "R7 repeated trigger ignored");
    wr(3'd4, 32'h2222);
    rdx(3'd2, 32'h100, "R7 changed trigger reloads");

    wr(3'd1, 32'h28);
    rdx(3'd1, 32'h28, "R10 control accepted while disarmed");
    wr(3'd6, 32'hBBBB); wr_raw(3'd6, 32'h4444); t0 = cyc;
    repeat (800) @(negedge clk);
    wr(3'd6, 32'hAAAA); wr_raw(3'd6, 32'h5555); dt = cyc - t0;
    repeat (64) @(negedge clk);
    rd(3'd2, 32'hFFFF_FFFF, 32'h100 + dt / 32 - 2, 32'h100 + dt / 32 + 2, "R10 prescaled advance");

    wr(3'd1, 32'h0);
    wr(3'd3, 32'hFFFF_FFF8);
    wr(3'd4, 32'h4444);
    rdx(3'd2, 32'hFFFF_FFF8, "R7 reload near overflow");
    chk(pulses == 0, "R11 no request before overflow", pulses, 0);
    wr(3'd6, 32'hBBBB); wr(3'd6, 32'h4444);
    repeat (400) @(negedge clk);
    wr(3'd6, 32'hAAAA); wr(3'd6, 32'h5555);
    chk(pulses >= 3, "R11 overflow requests", pulses, 3);
    chk(wide == 0, "R11 single-cycle request", wide, 0);
    rd(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFF8, 32'hFFFF_FFFF, "R11 wrap to load");
    p0 = pulses;
    repeat (400) @(negedge clk);
    chk(pulses == p0, "R11 no request while disarmed", pulses, p0);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R1 all reads returned", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule